// File: doc/BRIEF.md
# Comparator Offset Trim Calibration Controller

This block sits beside a successive-approximation converter and finds a trim code for the comparator's auxiliary input pair. It does this in the idle time after each conversion. Once every conversion bit is resolved, the sequencer signals end of conversion. The controller then ties both comparator inputs to common mode and uses one comparison to learn the sign of the offset. It steers the binary-weighted trim capacitor array to the auxiliary input that opposes that sign. It then raises the trial code by one on each calibration strobe until the comparator's decision turns over.

The code reached at that point is kept in a holding register, together with the side that was chosen. Both are applied to the trim array during the following conversions. While the converter samples, the controller grounds the trim array's top plate. All pins are plain control or status lines. There is no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `ofs_trim_ctrl`

## Requirements
- R1: A calibration run starts only when `conv_done_i` is high while the block is idle. `conv_done_i` has no effect while a run is in progress.
- R2: `short_cm_o` is high from the cycle after the accepted `conv_done_i` through the cycle in which the finishing strobe is taken. It falls in the cycle after that strobe.
- R3: The first accepted strobe of a run senses the offset sign. If `cmp_p_i` is high (positive offset), the run routes the array to the N side and `pol_n_o` = 1. Otherwise the run routes it to the P side and `pol_n_o` = 0. While the run is in progress, `pol_n_o` shows this sensed side.
- R4: The second accepted strobe sets the trial code to 0. In the counting phase, each accepted strobe without a decision change adds one to `trim_code_o`. Until counting starts, `trim_code_o` reads 0 during the run.
- R5: An accepted counting strobe at which `cmp_p_i` differs from the sensed sign ends the run. The current code and side move into the holding register, and `cal_done_o` is high for exactly one cycle, the cycle after that strobe.
- R6: `trim_rst_o` follows `sample_i` while the block is idle and stays low during a run.
- R7: While idle, `trim_code_o` and `pol_n_o` show the held code and side. After reset these are code 0 and P side (`pol_n_o` = 0).
- R8: An accepted counting strobe at code 31 with no decision change also ends the run. It holds code 31 and raises `cal_sat_o`, which stays high until a run ends without saturation. A decision change at code 31 takes priority, and `cal_sat_o` is then low.
- R9: A strobe is ignored, in every state, when its decision is not valid (`cmp_p_i` equal to `cmp_n_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| conv_done_i | input | 1 | all conversion bits resolved |
| sample_i | input | 1 | converter is in its sampling phase |
| cal_stb_i | input | 1 | calibration clock strobe, one cycle per comparison |
| cmp_p_i | input | 1 | comparator decision, P output |
| cmp_n_i | input | 1 | comparator decision, N output |
| short_cm_o | output | 1 | ties both comparator inputs to common mode |
| pol_n_o | output | 1 | 1 routes the trim array to the N side, 0 to the P side |
| trim_code_o | output | 5 | trim code driving the capacitor array |
| trim_rst_o | output | 1 | grounds the trim array top plate |
| cal_done_o | output | 1 | one-cycle pulse when a run ends |
| cal_sat_o | output | 1 | held code was reached by saturation |

## Verification
Two end conditions can fall on the same strobe: the decision change and the counter reaching its top value. The bench provokes this with a modelled offset of exactly +31 units. The comparator then first turns over at code 31. The check expects code 31 stored with `cal_sat_o` low, which shows that the change takes priority. A separate run with +40 units exercises pure saturation. Within runs, the bench also lands `conv_done_i`, `sample_i` and strobes with invalid decisions in the same cycles as accepted work, and checks that they leave the outputs untouched.

// File: rtl/ofs_trim_pkg.sv
package ofs_trim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SENSE = 2'd1,
    ST_START = 2'd2,
    ST_COUNT = 2'd3
  } cal_state_e;
endpackage

// File: rtl/ofs_trim_fsm.sv
module ofs_trim_fsm
  import ofs_trim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_done_i,
  input  logic       stb_ok_i,
  input  logic       flip_i,
  input  logic       at_max_i,
  output cal_state_e state_o,
  output logic       begin_o,
  output logic       ld_pol_o,
  output logic       clr_o,
  output logic       inc_o,
  output logic       fin_o,
  output logic       fin_sat_o
);
  cal_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    begin_o   = 1'b0;
    ld_pol_o  = 1'b0;
    clr_o     = 1'b0;
    inc_o     = 1'b0;
    fin_o     = 1'b0;
    fin_sat_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (conv_done_i) begin
          begin_o = 1'b1;
          st_d    = ST_SENSE;
        end
      end
      ST_SENSE: begin
        if (stb_ok_i) begin
          ld_pol_o = 1'b1;
          st_d     = ST_START;
        end
      end
      ST_START: begin
        if (stb_ok_i) begin
          clr_o = 1'b1;
          st_d  = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (stb_ok_i) begin
          if (flip_i) begin
            fin_o = 1'b1;
            st_d  = ST_IDLE;
          end else if (at_max_i) begin
            fin_o     = 1'b1;
            fin_sat_o = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            inc_o = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R5
  fin_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> (st_q == ST_IDLE));
endmodule

// File: rtl/ofs_trim_counter.sv
module ofs_trim_counter #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic              at_max_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt_q <= '0;
    else if (clr_i)                        cnt_q <= '0;
    else if (inc_i && (cnt_q != CODE_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CODE_MAX);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max_o && !clr_i) |=> at_max_o);
endmodule

// File: rtl/ofs_trim_hold.sv
module ofs_trim_hold #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_i,
  input  logic              fin_sat_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pol_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pol_o,
  output logic              sat_o,
  output logic              done_o
);
  logic [CODE_W-1:0] code_q;
  logic              pol_q, sat_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pol_q  <= 1'b0;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (fin_i) begin
        code_q <= code_i;
        pol_q  <= pol_i;
        sat_q  <= fin_sat_i;
      end
    end
  end

  assign code_o = code_q;
  assign pol_o  = pol_q;
  assign sat_o  = sat_q;
  assign done_o = done_q;

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ofs_trim_ctrl.sv
module ofs_trim_ctrl
  import ofs_trim_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done_i,
  input  logic              sample_i,
  input  logic              cal_stb_i,
  input  logic              cmp_p_i,
  input  logic              cmp_n_i,
  output logic              short_cm_o,
  output logic              pol_n_o,
  output logic [CODE_W-1:0] trim_code_o,
  output logic              trim_rst_o,
  output logic              cal_done_o,
  output logic              cal_sat_o
);
  cal_state_e        state;
  logic              begin_s, ld_pol, clr_s, inc_s, fin_s, fin_sat_s;
  logic              stb_ok, flip, at_max, busy;
  logic              run_pol_q;
  logic [CODE_W-1:0] cnt, held_code;
  logic              held_pol;

  assign stb_ok = cal_stb_i && (cmp_p_i ^ cmp_n_i);
  assign flip   = (cmp_p_i != run_pol_q);

  ofs_trim_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done_i(conv_done_i),
    .stb_ok_i   (stb_ok),
    .flip_i     (flip),
    .at_max_i   (at_max),
    .state_o    (state),
    .begin_o    (begin_s),
    .ld_pol_o   (ld_pol),
    .clr_o      (clr_s),
    .inc_o      (inc_s),
    .fin_o      (fin_s),
    .fin_sat_o  (fin_sat_s)
  );

  ofs_trim_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (begin_s || clr_s),
    .inc_i   (inc_s),
    .cnt_o   (cnt),
    .at_max_o(at_max)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_pol_q <= 1'b0;
    else if (begin_s) run_pol_q <= 1'b0;
    else if (ld_pol)  run_pol_q <= cmp_p_i;
  end

  ofs_trim_hold #(.CODE_W(CODE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_i    (fin_s),
    .fin_sat_i(fin_sat_s),
    .code_i   (cnt),
    .pol_i    (run_pol_q),
    .code_o   (held_code),
    .pol_o    (held_pol),
    .sat_o    (cal_sat_o),
    .done_o   (cal_done_o)
  );

  assign busy        = (state != ST_IDLE);
  assign short_cm_o  = busy;
  assign trim_code_o = busy ? cnt : held_code;
  assign pol_n_o     = busy ? run_pol_q : held_pol;
  assign trim_rst_o  = sample_i && !busy;

  // R6
  rst_not_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_cm_o |-> !trim_rst_o);

  // R7
  idle_code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!short_cm_o && !cal_done_o) |-> ($stable(trim_code_o) && $stable(pol_n_o)));

  // R4
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_cm_o && $past(short_cm_o) && trim_code_o != '0) |->
      (trim_code_o == $past(trim_code_o) ||
       trim_code_o == CODE_W'($past(trim_code_o) + 1'b1)));

  // R8
  sat_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_sat_o) |-> cal_done_o);

  // R9
  bad_stb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_cm_o && cal_stb_i && (cmp_p_i == cmp_n_i)) |=>
      ($stable(trim_code_o) && $stable(pol_n_o) && short_cm_o && !cal_done_o));

  // R1
  start_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!short_cm_o && conv_done_i) |=> short_cm_o);
endmodule

// File: tb/ofs_trim_ctrl_tb_top.sv
module ofs_trim_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done_i = 1'b0, sample_i = 1'b0, cal_stb_i = 1'b0;
  logic       cmp_p_i, cmp_n_i;
  logic       short_cm_o, pol_n_o, trim_rst_o, cal_done_o, cal_sat_o;
  logic [4:0] trim_code_o;

  int checks = 0, errors = 0;
  int offset = 0;
  bit cmp_bad = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ofs_trim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done_i(conv_done_i), .sample_i(sample_i),
    .cal_stb_i(cal_stb_i), .cmp_p_i(cmp_p_i), .cmp_n_i(cmp_n_i),
    .short_cm_o(short_cm_o), .pol_n_o(pol_n_o), .trim_code_o(trim_code_o),
    .trim_rst_o(trim_rst_o), .cal_done_o(cal_done_o), .cal_sat_o(cal_sat_o)
  );

  // comparator with shorted inputs plus trim array
  always_comb begin
    int eff;
    eff = pol_n_o ? (offset - int'(trim_code_o)) : (offset + int'(trim_code_o));
    cmp_p_i = cmp_bad ? 1'b0 : (eff > 0);
    cmp_n_i = cmp_bad ? 1'b0 : !(eff > 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, compared every clock
  int m_st = 0, m_cnt = 0, m_hold = 0;
  bit m_rpol = 0, m_hpol = 0, m_sat = 0, m_done = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_hold = 0; m_rpol = 0; m_hpol = 0; m_sat = 0; m_done = 0;
    end else begin
      bit busy, ok;
      busy = (m_st != 0);
      chk(short_cm_o == busy, "R2 short_cm", short_cm_o, busy);
      chk(int'(trim_code_o) == (busy ? m_cnt : m_hold), "R4/R7 trim_code",
          trim_code_o, busy ? m_cnt : m_hold);
      chk(pol_n_o == (busy ? m_rpol : m_hpol), "R3/R7 pol_n", pol_n_o, busy ? m_rpol : m_hpol);
      chk(cal_done_o == m_done, "R5 cal_done", cal_done_o, m_done);
      chk(cal_sat_o == m_sat, "R8 cal_sat", cal_sat_o, m_sat);
      chk(trim_rst_o == (sample_i && !busy), "R6 trim_rst", trim_rst_o, sample_i && !busy);
      ok = cal_stb_i && (cmp_p_i != cmp_n_i);   // R9
      m_done = 0;
      case (m_st)
        0: if (conv_done_i) begin m_st = 1; m_cnt = 0; m_rpol = 0; end   // R1
        1: if (ok) begin m_rpol = cmp_p_i; m_st = 2; end
        2: if (ok) begin m_cnt = 0; m_st = 3; end
        default: if (ok) begin
          if (cmp_p_i != m_rpol) begin
            m_hold = m_cnt; m_hpol = m_rpol; m_sat = 0; m_done = 1; m_st = 0;
          end else if (m_cnt == 31) begin
            m_hold = 31; m_hpol = m_rpol; m_sat = 1; m_done = 1; m_st = 0;
          end else m_cnt++;
        end
      endcase
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // one full run; bad_every>0 inserts an invalid strobe; disturb lands stray inputs mid-run
  task automatic run_cal(input int off, input int bad_every, input bit disturb);
    int exp_code, n;
    bit exp_pol, exp_sat, seen;
    offset = off;
    conv_done_i = 1'b1; step(); conv_done_i = 1'b0;
    n = 0; seen = 1'b0;
    while (!seen && n < 80) begin
      n++;
      cal_stb_i = 1'b1;
      cmp_bad = (bad_every > 0) && (n % bad_every == 0);
      if (disturb && n == 4) begin conv_done_i = 1'b1; sample_i = 1'b1; end
      step();
      cal_stb_i = 1'b0; cmp_bad = 1'b0; conv_done_i = 1'b0; sample_i = 1'b0;
      step();
      if (cal_done_o) seen = 1'b1;
    end
    // expected from the requirements
    if (off > 0) begin exp_pol = 1; exp_code = off; end
    else begin exp_pol = 0; exp_code = 1 - off; end
    exp_sat = (exp_code > 31);
    if (exp_sat) exp_code = 31;
    step();
    chk(int'(trim_code_o) == exp_code, "R5 held code", trim_code_o, exp_code);
    chk(pol_n_o == exp_pol, "R3 held side", pol_n_o, exp_pol);
    chk(cal_sat_o == exp_sat, "R8 saturation flag", cal_sat_o, exp_sat);
    chk(short_cm_o == 1'b0, "R2 back to idle", short_cm_o, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    // R7 reset state
    chk(trim_code_o == 5'd0, "R7 reset code", trim_code_o, 0);
    chk(pol_n_o == 1'b0, "R7 reset side", pol_n_o, 0);
    chk(cal_done_o == 1'b0, "R5 reset done", cal_done_o, 0);
    chk(cal_sat_o == 1'b0, "R8 reset sat", cal_sat_o, 0);
    chk(short_cm_o == 1'b0, "R2 reset short", short_cm_o, 0);
    step();
    // R6 sampling while idle
    sample_i = 1'b1; step();
    chk(trim_rst_o == 1'b1, "R6 sample grounds plate", trim_rst_o, 1);
    sample_i = 1'b0; step();
    // R9 strobes while idle with no start do nothing
    cal_stb_i = 1'b1; step(); cal_stb_i = 1'b0; step();
    chk(short_cm_o == 1'b0, "R1 strobe alone no start", short_cm_o, 0);
    run_cal(5, 0, 1'b0);      // positive offset
    run_cal(-3, 0, 1'b0);     // negative offset
    run_cal(40, 0, 1'b0);     // saturation
    run_cal(31, 0, 1'b0);     // flip and top code on same strobe
    run_cal(0, 3, 1'b1);      // invalid strobes, stray conv_done and sample
    run_cal(-12, 2, 1'b0);
    repeat (4) step();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule